// File: doc/BRIEF.md
# Cross-Domain Register Write Acknowledge

This block carries register writes from a fast bus clock domain into a slow timer clock domain. It tells software, one register at a time, when each write has really landed on the timer side. Nine registers are tracked. Each has its own crossing channel. A channel holds the written data steady, flips a request toggle toward the timer domain, and waits for the matching acknowledge toggle to come back.

When the acknowledge comes back, the channel returns to idle and sets that register's sticky write-applied bit. The bits sit in three status words. Software polls its bit, then clears it by writing a one. The timer-side logic is stood in for by a register file that the timer domain reads through an index port. An untracked scratch register lives entirely on the bus side.

Each bus-side channel runs a two-state machine:
- `CH_IDLE`: no write in flight. Transition *launch* (an accepted write) goes to `CH_WAIT`.
- `CH_WAIT`: data held and request toggled. Transition *complete* (the synchronized acknowledge equals the request) goes back to `CH_IDLE` and pulses the channel's done signal.

A second write to a busy channel raises `bus_wait` until that channel reaches `CH_IDLE`.

Top module: `xwack_top`

## Requirements
- R1: After reset all three status words read 0, `bus_wait` is low, and every timer-side register reads 0.
- R2: A write to tracked register index 0..8 is copied into the timer-side register of the same index. Its status bit is still 0 in the cycle after the write is accepted, and it only sets once the timer-side register holds the written value.
- R3: Status word A (address 10) reports index 0 at bit 3, index 1 at bit 1 and index 2 at bit 0.
- R4: Status word B (address 11) reports index 3 at bit 16, index 4 at bit 0, index 5 at bit 1 and index 6 at bit 2.
- R5: Status word C (address 12) reports index 7 at bit 0 and index 8 at bit 1.
- R6: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged. The bits are sticky and stay set until cleared.
- R7: A write to a tracked register whose previous write is still in flight sees `bus_wait` high and is held off. Once accepted, its value is the one that ends up in the timer-side register.
- R8: Writes to different tracked registers on consecutive cycles are all accepted without `bus_wait`, and every one of them completes.
- R9: A write to the scratch register (address 9) or to a status word never raises `bus_wait`. A scratch write is readable on the next cycle and sets no status bit.
- R10: A tracked write's status bit sets within 64 bus clocks of acceptance, and a channel never stays in `CH_WAIT` longer than that.
- R11: Reading a tracked register address returns the last value accepted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| rst_bus_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_wr | input | 1 | Write request |
| bus_addr | input | 4 | Write address (0..8 tracked, 9 scratch, 10..12 status) |
| bus_wdata | input | 32 | Write data |
| bus_wait | output | 1 | Write held off; keep request stable |
| bus_rd_addr | input | 4 | Read address |
| bus_rdata | output | 32 | Read data (combinational) |
| clk_tmr | input | 1 | Slow timer clock |
| rst_tmr_n | input | 1 | Active-low asynchronous reset, timer domain |
| tmr_idx | input | 4 | Timer-side register index |
| tmr_data | output | 32 | Timer-side register value |

## Verification
The assertions check several things on every cycle:
- data and request stay frozen while a channel is in `CH_WAIT`, and no channel stays there past the limit;
- a status bit only rises on a completion pulse;
- a one written to a status word clears the matching bit;
- a scratch write sets no status bit;
- a timer-side register changes only on a newly seen request edge.

Only the bench's scenarios can show certain things. These are the bit positions in each status word, the ordering between the timer-side value and the status bit, and that a stalled second write is the value that survives. The same holds for back-to-back writes to different channels all completing, and the contents the randomized mix of writes and clears leaves behind.

// File: rtl/xwack_pkg.sv
package xwack_pkg;

    localparam int NUM_CH      = 9;
    localparam int NUM_WORDS   = 3;
    localparam int ADDR_W      = 4;
    localparam logic [ADDR_W-1:0] ADR_SCRATCH = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_STAT0   = 4'd10;

    typedef enum logic {
        CH_IDLE,
        CH_WAIT
    } ch_state_t;

    // Status word that reports a channel.
    function automatic int unsigned ch_word(input int unsigned ch);
        if (ch <= 2)      return 0;
        else if (ch <= 6) return 1;
        else              return 2;
    endfunction

    // Bit position of a channel inside its status word.
    function automatic int unsigned ch_bit(input int unsigned ch);
        case (ch)
            0:       return 3;
            1:       return 1;
            2:       return 0;
            3:       return 16;
            4:       return 0;
            5:       return 1;
            6:       return 2;
            7:       return 0;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/xwack_chan_src.sv
module xwack_chan_src
    import xwack_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAX_WAIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_i,
    output logic [DATA_W-1:0] data_o,
    output logic              req_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(MAX_WAIT + 1) + 1;

    ch_state_t         state_q, state_d;
    logic              ack_s1, ack_s2;
    logic              req_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  wait_cnt;
    logic              done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state and completion pulse
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            CH_IDLE: if (launch) state_d = CH_WAIT;
            CH_WAIT: if (ack_s2 == req_q) begin
                done    = 1'b1;
                state_d = CH_IDLE;
            end
        endcase
    end

    // datapath and acknowledge synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_s1   <= 1'b0;
            ack_s2   <= 1'b0;
            req_q    <= 1'b0;
            data_q   <= '0;
            wait_cnt <= '0;
        end else begin
            ack_s1 <= ack_i;
            ack_s2 <= ack_s1;
            if (state_q == CH_IDLE && launch) begin
                data_q <= wdata;
                req_q  <= ~req_q;
            end
            if (state_q == CH_WAIT) wait_cnt <= wait_cnt + 1'b1;
            else                    wait_cnt <= '0;
        end
    end

    assign data_o = data_q;
    assign req_o  = req_q;
    assign busy_o = (state_q != CH_IDLE);
    assign done_o = done;

    a_r7_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && !done) |=> ($stable(data_q) && $stable(req_q)));

    a_r10_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < CNT_W'(MAX_WAIT));

endmodule

// File: rtl/xwack_chan_dst.sv
module xwack_chan_dst #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] val_o
);
    logic              req_s1, req_s2, req_s3;
    logic              ack_q;
    logic [DATA_W-1:0] val_q;
    logic              new_req;

    assign new_req = req_s2 ^ req_s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
            ack_q  <= 1'b0;
            val_q  <= '0;
        end else begin
            req_s1 <= req_i;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            ack_q  <= req_s2;
            if (new_req) val_q <= data_i;
        end
    end

    assign ack_o = ack_q;
    assign val_o = val_q;

    a_r2_apply_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(new_req) |-> $stable(val_q));

endmodule

// File: rtl/xwack_top.sv
module xwack_top
    import xwack_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAX_WAIT = 64
) (
    input  logic              clk_bus,
    input  logic              rst_bus_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wait,
    input  logic [3:0]        bus_rd_addr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clk_tmr,
    input  logic              rst_tmr_n,
    input  logic [3:0]        tmr_idx,
    output logic [DATA_W-1:0] tmr_data
);
    logic [NUM_CH-1:0]  busy, done, req, ack, launch, stat_clr;
    logic [NUM_CH-1:0]  stat_q;
    logic [DATA_W-1:0]  held   [NUM_CH];
    logic [DATA_W-1:0]  tval   [NUM_CH];
    logic [DATA_W-1:0]  stat_word [NUM_WORDS];
    logic [DATA_W-1:0]  scratch_q;
    logic               accept, tracked, scratch_wr;

    assign tracked = (bus_addr < ADDR_W'(NUM_CH));

    always_comb begin
        bus_wait = 1'b0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_wr && tracked && bus_addr == ADDR_W'(i) && busy[i]) bus_wait = 1'b1;
    end

    assign accept     = bus_wr && !bus_wait;
    assign scratch_wr = accept && (bus_addr == ADR_SCRATCH);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            launch[i]   = accept && (bus_addr == ADDR_W'(i));
            stat_clr[i] = accept && (bus_addr == ADR_STAT0 + ADDR_W'(ch_word(i)))
                          && bus_wdata[ch_bit(i)];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        xwack_chan_src #(.DATA_W(DATA_W), .MAX_WAIT(MAX_WAIT)) src_i (
            .clk    (clk_bus),
            .rst_n  (rst_bus_n),
            .launch (launch[g]),
            .wdata  (bus_wdata),
            .ack_i  (ack[g]),
            .data_o (held[g]),
            .req_o  (req[g]),
            .busy_o (busy[g]),
            .done_o (done[g])
        );
        xwack_chan_dst #(.DATA_W(DATA_W)) dst_i (
            .clk    (clk_tmr),
            .rst_n  (rst_tmr_n),
            .req_i  (req[g]),
            .data_i (held[g]),
            .ack_o  (ack[g]),
            .val_o  (tval[g])
        );

        a_r2_set_only_on_done: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
            $rose(stat_q[g]) |-> $past(done[g]));

        a_r6_w1c_clears: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
            (stat_clr[g] && !done[g]) |=> !stat_q[g]);
    end

    // sticky status and scratch register
    always_ff @(posedge clk_bus or negedge rst_bus_n) begin
        if (!rst_bus_n) begin
            stat_q    <= '0;
            scratch_q <= '0;
        end else begin
            stat_q <= done | (stat_q & ~stat_clr);
            if (scratch_wr) scratch_q <= bus_wdata;
        end
    end

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) stat_word[w] = '0;
        for (int i = 0; i < NUM_CH; i++) stat_word[ch_word(i)][ch_bit(i)] = stat_q[i];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_rd_addr == ADDR_W'(i)) bus_rdata = held[i];
        if (bus_rd_addr == ADR_SCRATCH) bus_rdata = scratch_q;
        for (int w = 0; w < NUM_WORDS; w++)
            if (bus_rd_addr == ADR_STAT0 + ADDR_W'(w)) bus_rdata = stat_word[w];
    end

    always_comb begin
        tmr_data = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (tmr_idx == ADDR_W'(i)) tmr_data = tval[i];
    end

    a_r9_scratch_sets_nothing: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (scratch_wr && done == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

    a_r9_untracked_never_waits: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (bus_wr && !tracked) |-> !bus_wait);

endmodule

// File: tb/xwack_top_tb_top.sv
module xwack_top_tb_top;
    localparam int NCH = 9;

    logic        clk_bus = 0, clk_tmr = 0;
    logic        rst_bus_n = 0, rst_tmr_n = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_addr = 0, bus_rd_addr = 0, tmr_idx = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_wait;
    logic [31:0] bus_rdata, tmr_data;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_val [NCH];
    bit          exp_st  [NCH];
    logic [31:0] exp_scr = 0;

    always #10 clk_bus = ~clk_bus;
    always #35 clk_tmr = ~clk_tmr;

    xwack_top dut_i (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wait(bus_wait), .bus_rd_addr(bus_rd_addr),
        .bus_rdata(bus_rdata), .clk_tmr(clk_tmr), .rst_tmr_n(rst_tmr_n),
        .tmr_idx(tmr_idx), .tmr_data(tmr_data)
    );

    function automatic int wd(int ch);
        return (ch <= 2) ? 0 : (ch <= 6) ? 1 : 2;
    endfunction
    function automatic int bp(int ch);
        int t [NCH] = '{3, 1, 0, 16, 0, 1, 2, 0, 1};
        return t[ch];
    endfunction
    function automatic logic [31:0] exp_word(int w);
        logic [31:0] r = 0;
        for (int i = 0; i < NCH; i++) if (wd(i) == w && exp_st[i]) r[bp(i)] = 1'b1;
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_rd_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic trd(int idx, output logic [31:0] d);
        tmr_idx = 4'(idx);
        #1 d = tmr_data;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, output bit stalled);
        @(negedge clk_bus);
        bus_wr = 1; bus_addr = a; bus_wdata = d; stalled = 0;
        #1;
        while (bus_wait) begin
            stalled = 1;
            @(negedge clk_bus);
            #1;
        end
        @(posedge clk_bus);
        #1 bus_wr = 0;
    endtask

    task automatic poll(int ch, output int cyc);
        logic [31:0] d;
        cyc = 0;
        do begin
            rd(4'(10 + wd(ch)), d);
            cyc++;
        end while (!d[bp(ch)] && cyc < 200);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, v, v2;
        bit st;
        int cyc;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NCH; i++) begin exp_val[i] = 0; exp_st[i] = 0; end
        #95 rst_bus_n = 1; rst_tmr_n = 1;
        repeat (3) @(posedge clk_bus);

        // R1 reset state
        for (int w = 0; w < 3; w++) begin
            rd(4'(10 + w), d);
            chk(d == 0, "R1 status word", d, 0);
        end
        chk(bus_wait == 0, "R1 wait", 32'(bus_wait), 0);
        for (int i = 0; i < NCH; i++) begin
            trd(i, d);
            chk(d == 0, "R1 timer reg", d, 0);
        end

        // R2..R6, R10 per channel
        for (int ch = 0; ch < NCH; ch++) begin
            v = $urandom;
            wr(4'(ch), v, st);
            exp_val[ch] = v;
            rd(4'(10 + wd(ch)), d);
            chk(d[bp(ch)] == 0, "R2 status early", d, 0);
            poll(ch, cyc);
            chk(cyc <= 64, "R10 bound", 32'(cyc), 64);
            trd(ch, d);
            chk(d == v, "R2 applied before status", d, v);
            exp_st[ch] = 1;
            rd(4'(10 + wd(ch)), d);
            if (wd(ch) == 0)      chk(d == exp_word(0), "R3 word A", d, exp_word(0));
            else if (wd(ch) == 1) chk(d == exp_word(1), "R4 word B", d, exp_word(1));
            else                  chk(d == exp_word(2), "R5 word C", d, exp_word(2));
            wr(4'(10 + wd(ch)), 32'h0, st);
            rd(4'(10 + wd(ch)), d);
            chk(d == exp_word(wd(ch)), "R6 zero keeps", d, exp_word(wd(ch)));
            wr(4'(10 + wd(ch)), 32'h1 << bp(ch), st);
            exp_st[ch] = 0;
            rd(4'(10 + wd(ch)), d);
            chk(d == exp_word(wd(ch)), "R6 one clears", d, exp_word(wd(ch)));
            rd(4'(ch), d);
            chk(d == v, "R11 readback", d, v);
        end

        // R7 stall on busy channel
        v = $urandom; v2 = $urandom;
        wr(4'd1, v, st);
        wr(4'd1, v2, st);
        chk(st == 1, "R7 wait seen", 32'(st), 1);
        exp_val[1] = v2; exp_st[1] = 1;
        repeat (70) @(posedge clk_bus);
        trd(1, d);
        chk(d == v2, "R7 final value", d, v2);
        rd(4'd10, d);
        chk(d == exp_word(0), "R7 status", d, exp_word(0));

        // R8 back-to-back different channels
        begin
            bit any = 0;
            for (int ch = 3; ch <= 6; ch++) begin
                v = $urandom;
                wr(4'(ch), v, st);
                any |= st;
                exp_val[ch] = v; exp_st[ch] = 1;
            end
            chk(any == 0, "R8 no wait", 32'(any), 0);
        end
        repeat (70) @(posedge clk_bus);
        rd(4'd11, d);
        chk(d == exp_word(1), "R8 all complete", d, exp_word(1));
        for (int ch = 3; ch <= 6; ch++) begin
            trd(ch, d);
            chk(d == exp_val[ch], "R8 value", d, exp_val[ch]);
        end

        // R9 scratch
        v = $urandom;
        wr(4'd9, v, st);
        exp_scr = v;
        chk(st == 0, "R9 no wait", 32'(st), 0);
        rd(4'd9, d);
        chk(d == v, "R9 readback", d, v);
        repeat (70) @(posedge clk_bus);
        for (int w = 0; w < 3; w++) begin
            rd(4'(10 + w), d);
            chk(d == exp_word(w), "R9 status untouched", d, exp_word(w));
        end

        // random mix
        for (int it = 0; it < 30; it++) begin
            int a = $urandom_range(12, 0);
            v = $urandom;
            if (a >= 10) begin
                wr(4'(a), v, st);
                for (int i = 0; i < NCH; i++) if (wd(i) == a - 10 && v[bp(i)]) exp_st[i] = 0;
            end else begin
                wr(4'(a), v, st);
                if (a == 9) exp_scr = v;
                else begin exp_val[a] = v; exp_st[a] = 1; end
            end
            repeat (70) @(posedge clk_bus);
            for (int w = 0; w < 3; w++) begin
                rd(4'(10 + w), d);
                chk(d == exp_word(w), "R6 random status", d, exp_word(w));
            end
            if (a < 9) begin
                rd(4'(a), d);
                chk(d == exp_val[a], "R11 random readback", d, exp_val[a]);
                trd(a, d);
                chk(d == exp_val[a], "R2 random applied", d, exp_val[a]);
            end else if (a == 9) begin
                rd(4'd9, d);
                chk(d == exp_scr, "R9 random scratch", d, exp_scr);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule